// File: doc/BRIEF.md
# Shared Multi-FIFO Packet Store

This block is the storage pool of a router input stage. Several input channels deliver variable-length packets as streams of flits, each with a valid/ready handshake and a tail flag. Storage is a set of equal FIFOs, each `DEPTH_MULT * MAX_PKT` flits deep. A FIFO can hold several packets back to back, so the input side needs no record of where each packet lies.

When the first flit of a packet arrives, the control binds the channel to one FIFO. That FIFO must have a free write port and room for a packet of the largest size. The binding stays in place until the tail flit is accepted. A global count of stored flits limits the pool to a configured capacity `CAP`, which is below the physical total. This leaves every packet that has been admitted room to wait at a FIFO head. Each FIFO head has its own output port with a pop strobe, and the logic that drains those ports sits outside this block.

For the limit to give the guarantees it is meant to give, `CAP` should satisfy `d*DEPTH_MULT*MAX_PKT < CAP < (NUM_FIFO-d+1)*((DEPTH_MULT-1)*MAX_PKT+1)` for the chosen reserve count `d`. The default configuration is 4 FIFOs, a depth factor of 3, 8-flit packets and `CAP` = 40, which fits `d` = 1.

Top module: `pkt_pool`

## Requirements
- R1: After reset every FIFO is empty, every `outValid` bit is low and every `inReady` bit is high.
- R2: Each FIFO presents its oldest flit on its `outData` slice and its tail flag on `outLast`, with `outValid` high while it is not empty. A pop removes one flit. A pop on an empty FIFO changes nothing.
- R3: The first flit of a packet from an unbound channel is written to the lowest-indexed FIFO that no channel is bound to and that holds at most `DEPTH - MAX_PKT` flits.
- R4: When no FIFO meets the condition of R3, the header sees `inReady` low in that cycle and is not accepted.
- R5: Every later flit of a packet goes to the FIFO chosen for its header. A channel is released in the cycle its tail flit (`inLast` = 1) is accepted. A one-flit packet never binds. No other channel can select a FIFO while a channel is bound to it.
- R6: Channels are served in index order within a cycle. A FIFO taken by a lower channel's accepted header is not eligible for a higher channel in the same cycle.
- R7: The number of stored flits never exceeds `CAP`. A flit is accepted only if the stored count, plus the flits already accepted from lower channels in that cycle, is below `CAP`. Pops in the same cycle do not free room until the next cycle.
- R8: A push and a pop on the same FIFO in one cycle both take effect.
- R9: A FIFO holds flits in arrival order, with the flits of each packet contiguous, and can hold several packets at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | NUM_CH | Flit offered on each input channel |
| inLast | input | NUM_CH | Offered flit is the tail of its packet |
| inData | input | NUM_CH*DATA_W | Flit payload; channel c in bits c*DATA_W upward |
| inReady | output | NUM_CH | Channel flit accepted this cycle if valid |
| outValid | output | NUM_FIFO | FIFO head holds a flit |
| outLast | output | NUM_FIFO | FIFO head flit is a tail |
| outData | output | NUM_FIFO*DATA_W | FIFO head payload; FIFO f in bits f*DATA_W upward |
| outPop | input | NUM_FIFO | Remove the head flit of each FIFO |

## Verification
The bench drives headers on both channels in the same cycle, so that a design which let the second channel take the FIFO the first just claimed would merge two packets in one queue and show interleaved flits at a head. A burst phase with no pops drives the stored count to `CAP`. An off-by-one limit, or one that credited same-cycle pops, would raise `inReady` one flit too early. Random pops hit empty FIFOs and FIFOs being written. A design that dropped the simultaneous push, or decremented an empty count, would show a wrong head or a spurious `outValid`. Packets of length one test that a channel is not left bound after its tail, which would otherwise lock a FIFO against headers from every other channel.

// File: rtl/pkt_pool_pkg.sv
package pkt_pool_pkg;
  // Widest channel select carried in a strobe (up to 16 input channels).
  localparam int SRC_W = 4;

  // Per-FIFO write strobe from the control to the datapath.
  typedef struct packed {
    logic             push;
    logic [SRC_W-1:0] src;
  } fifoStrobe_t;
endpackage

// File: rtl/pool_ctrl.sv
module pool_ctrl
  import pkt_pool_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int NUM_FIFO   = 4,
  parameter int MAX_PKT    = 8,
  parameter int DEPTH_MULT = 3,
  parameter int CAP        = 40,
  localparam int DEPTH = DEPTH_MULT * MAX_PKT,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int OCC_W = $clog2(CAP + 1),
  localparam int FI_W  = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_CH-1:0]                inValid,
  input  logic [NUM_CH-1:0]                inLast,
  output logic [NUM_CH-1:0]                inReady,
  input  logic [NUM_FIFO-1:0]              outPop,
  input  logic [NUM_FIFO-1:0][CNT_W-1:0]   fill,
  output fifoStrobe_t [NUM_FIFO-1:0]       strobe,
  output logic [OCC_W-1:0]                 occ,
  output logic [NUM_CH-1:0]                chanBound
);
  localparam logic [CNT_W-1:0] ELIG_MAX = CNT_W'(DEPTH - MAX_PKT);

  logic [NUM_CH-1:0][FI_W-1:0] bindIdx;
  logic [NUM_CH-1:0][FI_W-1:0] chanTgt;
  logic [NUM_CH-1:0]           accept;
  logic [NUM_FIFO-1:0]         fifoBusy;
  logic [NUM_FIFO-1:0]         popHit;
  logic [NUM_FIFO-1:0]         claimed;
  logic [OCC_W:0]              budget;
  logic                        found;
  logic [FI_W-1:0]             tgt;

  // FIFOs whose write port is held by an in-progress packet
  always_comb begin
    fifoBusy = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (chanBound[c]) fifoBusy[bindIdx[c]] = 1'b1;
  end

  always_comb begin
    for (int f = 0; f < NUM_FIFO; f++) popHit[f] = outPop[f] && (fill[f] != '0);
  end

  // Channel-ordered allocation with a running flit budget
  always_comb begin
    budget  = {1'b0, occ};
    claimed = fifoBusy;
    strobe  = '0;
    inReady = '0;
    accept  = '0;
    chanTgt = '0;
    found   = 1'b0;
    tgt     = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      found = 1'b0;
      tgt   = '0;
      if (chanBound[c]) begin
        found = 1'b1;
        tgt   = bindIdx[c];
      end else begin
        for (int f = 0; f < NUM_FIFO; f++) begin
          if (!found && !claimed[f] && fill[f] <= ELIG_MAX) begin
            found = 1'b1;
            tgt   = FI_W'(f);
          end
        end
      end
      inReady[c] = found && (budget < (OCC_W+1)'(CAP));
      accept[c]  = inValid[c] && inReady[c];
      chanTgt[c] = tgt;
      if (accept[c]) begin
        strobe[tgt].push = 1'b1;
        strobe[tgt].src  = SRC_W'(c);
        claimed[tgt]     = 1'b1;
        budget           = budget + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ       <= '0;
      chanBound <= '0;
      bindIdx   <= '0;
    end else begin
      occ <= occ + OCC_W'($countones(accept)) - OCC_W'($countones(popHit));
      for (int c = 0; c < NUM_CH; c++) begin
        if (accept[c]) begin
          chanBound[c] <= !inLast[c];
          bindIdx[c]   <= chanTgt[c];
        end
      end
    end
  end
endmodule

// File: rtl/pool_data.sv
module pool_data
  import pkt_pool_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int NUM_FIFO   = 4,
  parameter int MAX_PKT    = 8,
  parameter int DEPTH_MULT = 3,
  parameter int DATA_W     = 8,
  localparam int DEPTH = DEPTH_MULT * MAX_PKT,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_CH-1:0]              inLast,
  input  logic [NUM_CH*DATA_W-1:0]       inData,
  input  fifoStrobe_t [NUM_FIFO-1:0]     strobe,
  input  logic [NUM_FIFO-1:0]            outPop,
  output logic [NUM_FIFO-1:0][CNT_W-1:0] fill,
  output logic [NUM_FIFO-1:0]            outValid,
  output logic [NUM_FIFO-1:0]            outLast,
  output logic [NUM_FIFO*DATA_W-1:0]     outData
);
  for (genvar f = 0; f < NUM_FIFO; f++) begin : g_fifo
    logic [DATA_W:0]    mem [DEPTH];
    logic [PTR_W-1:0]   wrPtr, rdPtr;
    logic [CNT_W-1:0]   cnt;
    logic [DATA_W:0]    wrWord;
    logic               doPop;

    always_comb begin
      wrWord = '0;
      for (int c = 0; c < NUM_CH; c++)
        if (strobe[f].src == SRC_W'(c))
          wrWord = {inLast[c], inData[c*DATA_W +: DATA_W]};
    end

    assign doPop = outPop[f] && (cnt != '0);

    always_ff @(posedge clk) begin
      if (strobe[f].push) mem[wrPtr] <= wrWord;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wrPtr <= '0;
        rdPtr <= '0;
        cnt   <= '0;
      end else begin
        if (strobe[f].push)
          wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        if (doPop)
          rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        cnt <= cnt + CNT_W'(strobe[f].push) - CNT_W'(doPop);
      end
    end

    assign fill[f]                     = cnt;
    assign outValid[f]                 = (cnt != '0);
    assign outLast[f]                  = mem[rdPtr][DATA_W];
    assign outData[f*DATA_W +: DATA_W] = mem[rdPtr][DATA_W-1:0];
  end
endmodule

// File: rtl/pkt_pool.sv
module pkt_pool
  import pkt_pool_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int NUM_FIFO   = 4,
  parameter int MAX_PKT    = 8,
  parameter int DEPTH_MULT = 3,
  parameter int CAP        = 40,
  parameter int DATA_W     = 8,
  localparam int DEPTH = DEPTH_MULT * MAX_PKT,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int OCC_W = $clog2(CAP + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CH-1:0]          inValid,
  input  logic [NUM_CH-1:0]          inLast,
  input  logic [NUM_CH*DATA_W-1:0]   inData,
  output logic [NUM_CH-1:0]          inReady,
  output logic [NUM_FIFO-1:0]        outValid,
  output logic [NUM_FIFO-1:0]        outLast,
  output logic [NUM_FIFO*DATA_W-1:0] outData,
  input  logic [NUM_FIFO-1:0]        outPop
);
  fifoStrobe_t [NUM_FIFO-1:0]     strobe;
  logic [NUM_FIFO-1:0][CNT_W-1:0] fill;
  logic [OCC_W-1:0]               occ;
  logic [NUM_CH-1:0]              chanBound;

  pool_ctrl #(
    .NUM_CH(NUM_CH), .NUM_FIFO(NUM_FIFO), .MAX_PKT(MAX_PKT),
    .DEPTH_MULT(DEPTH_MULT), .CAP(CAP)
  ) ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .outPop(outPop), .fill(fill), .strobe(strobe),
    .occ(occ), .chanBound(chanBound)
  );

  pool_data #(
    .NUM_CH(NUM_CH), .NUM_FIFO(NUM_FIFO), .MAX_PKT(MAX_PKT),
    .DEPTH_MULT(DEPTH_MULT), .DATA_W(DATA_W)
  ) data (
    .clk(clk), .rst(rst), .inLast(inLast), .inData(inData),
    .strobe(strobe), .outPop(outPop), .fill(fill), .outValid(outValid),
    .outLast(outLast), .outData(outData)
  );
endmodule

// File: rtl/pkt_pool_chk.sv
module pkt_pool_chk #(
  parameter int NUM_CH   = 2,
  parameter int NUM_FIFO = 4,
  parameter int CAP      = 40,
  parameter int OCC_W    = 6
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_CH-1:0]   inValid,
  input logic [NUM_CH-1:0]   inReady,
  input logic [NUM_CH-1:0]   inLast,
  input logic [NUM_FIFO-1:0] outValid,
  input logic [NUM_FIFO-1:0] outPop,
  input logic [OCC_W-1:0]    occ,
  input logic [NUM_CH-1:0]   chanBound
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= CAP); // R7

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    (int'(occ) == CAP) |-> (inReady == '0)); // R7

  AST_OCC_TRACK: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> int'(occ) == int'($past(occ)) + $countones($past(inValid & inReady))
                   - $countones($past(outPop & outValid))); // R8

  AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (rst)
    (occ == '0) |-> (outValid == '0)); // R2

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_BIND_HOLD: assert property (@(posedge clk) disable iff (rst)
      (inValid[c] && inReady[c] && !inLast[c]) |=> chanBound[c]); // R5

    AST_BIND_FREE: assert property (@(posedge clk) disable iff (rst)
      (inValid[c] && inReady[c] && inLast[c]) |=> !chanBound[c]); // R5

    AST_BOUND_READY: assert property (@(posedge clk) disable iff (rst)
      (chanBound[c] && int'(occ) + NUM_CH <= CAP) |-> inReady[c]); // R5
  end
endmodule

bind pkt_pool pkt_pool_chk #(
  .NUM_CH(NUM_CH), .NUM_FIFO(NUM_FIFO), .CAP(CAP), .OCC_W(OCC_W)
) chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .inLast(inLast), .outValid(outValid), .outPop(outPop), .occ(occ),
  .chanBound(chanBound)
);

// File: tb/pkt_pool_test.sv
`timescale 1ns/1ps
module pkt_pool_test;
  localparam int NCH   = 2;
  localparam int NF    = 4;
  localparam int MAXP  = 8;
  localparam int KMUL  = 3;
  localparam int CAP   = 40;
  localparam int W     = 8;
  localparam int DEPTH = KMUL * MAXP;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCH-1:0]    inValid = '0;
  logic [NCH-1:0]    inLast = '0;
  logic [NCH*W-1:0]  inData = '0;
  logic [NCH-1:0]    inReady;
  logic [NF-1:0]     outValid;
  logic [NF-1:0]     outLast;
  logic [NF*W-1:0]   outData;
  logic [NF-1:0]     outPop = '0;

  always #2.5 clk = ~clk;

  pkt_pool #(.NUM_CH(NCH), .NUM_FIFO(NF), .MAX_PKT(MAXP), .DEPTH_MULT(KMUL),
             .CAP(CAP), .DATA_W(W)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outLast(outLast),
    .outData(outData), .outPop(outPop));

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  // behavioural reference state
  logic [W:0] mq [NF][$];
  bit         mBound [NCH];
  int         mIdx   [NCH];
  int         remLen [NCH];
  int         seqNo  [NCH];

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int stored();
    int s = 0;
    for (int f = 0; f < NF; f++) s += mq[f].size();
    return s;
  endfunction

  task automatic step(int validPct, int popPct, int maxLen);
    bit expR [NCH];
    int tgt  [NCH];
    bit claimed [NF];
    int budget;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      if (remLen[c] == 0) remLen[c] = 1 + int'($urandom % maxLen);
      inValid[c] = (int'($urandom % 100) < validPct);
      inLast[c]  = (remLen[c] == 1);
      inData[c*W +: W] = W'((c << 7) | (seqNo[c] & 127));
    end
    for (int f = 0; f < NF; f++) outPop[f] = (int'($urandom % 100) < popPct);
    #1;
    // expected readiness, channels in index order (R3 R4 R6 R7)
    budget = stored();
    for (int f = 0; f < NF; f++) claimed[f] = 0;
    for (int c = 0; c < NCH; c++) if (mBound[c]) claimed[mIdx[c]] = 1;
    for (int c = 0; c < NCH; c++) begin
      tgt[c] = -1;
      if (mBound[c]) tgt[c] = mIdx[c];
      else
        for (int f = 0; f < NF; f++)
          if (tgt[c] < 0 && !claimed[f] && mq[f].size() <= DEPTH - MAXP) tgt[c] = f;
      expR[c] = (tgt[c] >= 0) && (budget < CAP);
      if (expR[c] && inValid[c]) begin
        claimed[tgt[c]] = 1;
        budget++;
      end
      check(inReady[c] == expR[c], "R4 R6 R7", $sformatf("inReady[%0d]", c),
            int'(inReady[c]), int'(expR[c]));
    end
    // heads (R2 R3 R5 R9)
    for (int f = 0; f < NF; f++) begin
      check(outValid[f] == (mq[f].size() != 0), "R2", $sformatf("outValid[%0d]", f),
            int'(outValid[f]), int'(mq[f].size() != 0));
      if (mq[f].size() != 0) begin
        check({outLast[f], outData[f*W +: W]} == mq[f][0], "R3 R5 R9",
              $sformatf("head[%0d]", f), int'({outLast[f], outData[f*W +: W]}),
              int'(mq[f][0]));
      end
    end
    // model update: pops on pre-state, then pushes (R8)
    for (int f = 0; f < NF; f++)
      if (outPop[f] && mq[f].size() != 0) void'(mq[f].pop_front());
    for (int c = 0; c < NCH; c++) begin
      if (inValid[c] && expR[c]) begin
        mq[tgt[c]].push_back({inLast[c], inData[c*W +: W]});
        mBound[c] = !inLast[c];
        mIdx[c]   = tgt[c];
        seqNo[c]++;
        remLen[c]--;
      end
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      mBound[c] = 0; mIdx[c] = 0; remLen[c] = 0; seqNo[c] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    check(outValid == '0, "R1", "outValid after reset", int'(outValid), 0);
    check(inReady == '1, "R1", "inReady after reset", int'(inReady), (1 << NCH) - 1);
    // one-flit packets on both channels at once (R5 R6)
    repeat (40)   step(100, 30, 1);
    // fill to the capacity with no pops (R7 R4)
    repeat (300)  step(90, 0, MAXP);
    // mixed traffic with pops on full and empty FIFOs (R2 R8 R9)
    repeat (2500) step(70, 40, MAXP);
    // short packets, heavy contention (R3 R6)
    repeat (800)  step(100, 25, 3);
    // drain (R2)
    repeat (400)  step(20, 90, MAXP);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule